// File: doc/BRIEF.md
# Serial Port-Expander Sequencer

This block lets a host reach six bidirectional 8-bit ports that sit on a board of daisy-chained shift registers. The board carries one chain of serial-in/parallel-out registers with a storage latch, and one separate chain of parallel-in/serial-out registers with a parallel-load strobe. The output chain holds the six port data registers and one extra register at its far end. Each bit of that extra register sets whether one port drives its byte or stays high-impedance.

For a write, the host presents six output bytes and a six-bit direction mask, then raises the write request. The block captures these values and shifts the direction byte into the chain first and the port bytes after it. It then pulses the storage latch so that all pins change together. For a read, the block pulses the input chain's load strobe and clocks 48 bits back in. When the last bit arrives it updates the readable input bytes in a single step.

The serial clock is the system clock divided by a parameter. Only one transfer runs at a time, and a busy flag tells the host when a new request will be accepted.

Top module: `spx_ctrl`

## Requirements
- R1: While reset is held and after it is released, `ser_clk`, `ser_out`, `out_latch`, `in_load` and `busy` are 0 and `in_bytes` is all zeros.
- R2: A write shifts 56 bits MSB-first on `ser_out`. The direction byte goes first: bit p is `dir_mask[p]` (1 = port p drives, 0 = port p high-impedance), and bits 7:6 are 0. Port 5 down to port 0 follow, where port p is `out_bytes[8p+7:8p]`. After the latch, the output chain therefore holds {direction byte, port 5, ..., port 0}.
- R3: One serial bit lasts `CLK_DIV` system cycles. `ser_clk` is low for the first half of the bit and high for the second half. `ser_out` changes only at the start of a bit (the falling edge) and stays stable while `ser_clk` is high.
- R4: After the 56th write bit, `out_latch` is high for exactly `CLK_DIV` cycles while `ser_clk` stays low. The transfer then ends.
- R5: A read begins with `in_load` high for exactly `CLK_DIV` cycles while `ser_clk` stays low.
- R6: A read then takes 48 bits. Each bit is sampled from `ser_in` in the cycle before `ser_clk` would rise. The first bit is port 5 bit 7 and the last is port 0 bit 0, and port p lands in `in_bytes[8p+7:8p]`. The last sample ends the transfer without a further `ser_clk` rise.
- R7: `busy` rises in the cycle after a request is accepted. It stays high for 57·`CLK_DIV` cycles for a write and for 48·`CLK_DIV`+`CLK_DIV`/2 cycles for a read.
- R8: A request is accepted only while `busy` is low; requests that arrive while it is high are ignored. When `wr_req` and `rd_req` are both high, the write is taken and the read is dropped.
- R9: Changes to `out_bytes` or `dir_mask` after a write is accepted do not affect that transfer.
- R10: `in_bytes` keeps its previous value for the whole of a read and changes only in the cycle `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Request to push the direction mask and output bytes to the board |
| rd_req | input | 1 | Request to fetch the input bytes from the board |
| dir_mask | input | 6 | Per-port drive enable, 1 = drive |
| out_bytes | input | 48 | Output bytes, port p at bits 8p+7:8p |
| in_bytes | output | 48 | Last bytes read, port p at bits 8p+7:8p |
| busy | output | 1 | Transfer in progress |
| ser_clk | output | 1 | Shared serial clock for both chains |
| ser_out | output | 1 | Serial data into the output chain |
| ser_in | input | 1 | Serial data from the input chain |
| out_latch | output | 1 | Storage latch strobe for the output chain |
| in_load | output | 1 | Parallel-load strobe for the input chain |

## Verification
The bench compares the block against a cycle-level timing model on every clock, and a model of the board checks the bytes that land on it.

- **Bit order and direction byte.** It drives ports with asymmetric bytes and masks. A design with the wrong bit order, reversed port order or a misplaced direction byte would load the wrong bits onto the board's pins.
- **Requests during a transfer.** It issues requests while a transfer is running and also raises both requests together. A design that accepted either would start a stray load strobe or overwrite the board.
- **Inputs changing mid-write.** It changes the inputs halfway through a write. A design that kept reading them live would latch a mix of old and new bytes.
- **Last read bit and held input bytes.** It checks the truncated final read bit and reads `in_bytes` in the middle of a read. An off-by-one bit counter would shift the assembled bytes or produce an extra serial clock, and a design without a holding register would expose partial bytes.

// File: rtl/spx_pkg.sv
package spx_pkg;

  typedef enum logic [2:0] {
    SPX_IDLE   = 3'd0,
    SPX_WSHIFT = 3'd1,
    SPX_WLATCH = 3'd2,
    SPX_RLOAD  = 3'd3,
    SPX_RSHIFT = 3'd4
  } spx_state_e;

endpackage

// File: rtl/spx_rst_sync.sv
module spx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_ns = sync_q[1];

endmodule

// File: rtl/spx_sclk_gen.sv
module spx_sclk_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic run,
  input  logic shift_en,
  output logic sclk,
  output logic rise_tick,
  output logic period_end
);

  localparam int HALF = CLK_DIV / 2;
  localparam int PH_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!run) begin
      phase_d = '0;
    end else if (phase_q == PH_W'(CLK_DIV - 1)) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign period_end = run && (phase_q == PH_W'(CLK_DIV - 1));
  assign rise_tick  = run && (phase_q == PH_W'(HALF - 1));
  assign sclk       = shift_en && (phase_q >= PH_W'(HALF));

  AST_SCLK_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(sclk) |-> (phase_q == '0 || !shift_en)) // R3
    else $error("serial clock fell mid-bit");

endmodule

// File: rtl/spx_tx_shift.sv
module spx_tx_shift #(
  parameter int W = 56
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         out_en,
  output logic         sdo
);

  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_val;
    end else if (shift) begin
      sh_d = {sh_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign sdo = out_en & sh_q[W-1];

  AST_TX_LOAD_XOR_SHIFT: assert property (@(posedge clk) disable iff (!rst_ns)
    !(load && shift)) // R2
    else $error("transmit load and shift together");

endmodule

// File: rtl/spx_rx_shift.sv
module spx_rx_shift #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic         shift,
  input  logic         sdi,
  input  logic         commit,
  output logic [W-1:0] data_out
);

  logic [W-1:0] cap_q;
  logic [W-1:0] cap_d;
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  always_comb begin
    cap_d  = shift ? {cap_q[W-2:0], sdi} : cap_q;
    hold_d = commit ? cap_d : hold_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cap_q  <= '0;
      hold_q <= '0;
    end else begin
      cap_q  <= cap_d;
      hold_q <= hold_d;
    end
  end

  assign data_out = hold_q;

  AST_RX_COMMIT_WITH_SHIFT: assert property (@(posedge clk) disable iff (!rst_ns)
    commit |-> shift) // R6
    else $error("commit without final sample");

endmodule

// File: rtl/spx_ctrl.sv
module spx_ctrl #(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 8,
  parameter int CLK_DIV   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_req,
  input  logic                        rd_req,
  input  logic [NUM_PORTS-1:0]        dir_mask,
  input  logic [NUM_PORTS*PORT_W-1:0] out_bytes,
  output logic [NUM_PORTS*PORT_W-1:0] in_bytes,
  output logic                        busy,
  output logic                        ser_clk,
  output logic                        ser_out,
  input  logic                        ser_in,
  output logic                        out_latch,
  output logic                        in_load
);

  import spx_pkg::*;

  localparam int RX_BITS = NUM_PORTS * PORT_W;
  localparam int TX_BITS = RX_BITS + PORT_W;
  localparam int CNT_W   = $clog2(TX_BITS);

  logic               rst_ns;
  spx_state_e         state_q, state_d;
  logic [CNT_W-1:0]   bcnt_q, bcnt_d;
  logic               tx_load, tx_shift, rx_shift, rx_commit;
  logic               run, shift_en, rise_tick, period_end;
  logic [PORT_W-1:0]  en_byte;

  spx_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  // Direction byte: one enable per port, unused upper bits forced low.
  always_comb begin
    en_byte = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      en_byte[p] = dir_mask[p];
    end
  end

  always_comb begin
    state_d   = state_q;
    bcnt_d    = bcnt_q;
    tx_load   = 1'b0;
    tx_shift  = 1'b0;
    rx_shift  = 1'b0;
    rx_commit = 1'b0;
    case (state_q)
      SPX_IDLE: begin
        bcnt_d = '0;
        if (wr_req) begin
          state_d = SPX_WSHIFT;
          tx_load = 1'b1;
        end else if (rd_req) begin
          state_d = SPX_RLOAD;
        end
      end
      SPX_WSHIFT: begin
        if (period_end) begin
          if (bcnt_q == CNT_W'(TX_BITS - 1)) begin
            state_d = SPX_WLATCH;
            bcnt_d  = '0;
          end else begin
            bcnt_d   = bcnt_q + CNT_W'(1);
            tx_shift = 1'b1;
          end
        end
      end
      SPX_WLATCH: begin
        if (period_end) begin
          state_d = SPX_IDLE;
        end
      end
      SPX_RLOAD: begin
        if (period_end) begin
          state_d = SPX_RSHIFT;
          bcnt_d  = '0;
        end
      end
      SPX_RSHIFT: begin
        if (rise_tick) begin
          rx_shift = 1'b1;
          if (bcnt_q == CNT_W'(RX_BITS - 1)) begin
            state_d   = SPX_IDLE;
            rx_commit = 1'b1;
            bcnt_d    = '0;
          end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end
      default: begin
        state_d = SPX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= SPX_IDLE;
      bcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
    end
  end

  assign run       = (state_q != SPX_IDLE);
  assign shift_en  = (state_q == SPX_WSHIFT) || (state_q == SPX_RSHIFT);
  assign busy      = run;
  assign out_latch = (state_q == SPX_WLATCH);
  assign in_load   = (state_q == SPX_RLOAD);

  spx_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .run        (run),
    .shift_en   (shift_en),
    .sclk       (ser_clk),
    .rise_tick  (rise_tick),
    .period_end (period_end)
  );

  spx_tx_shift #(.W(TX_BITS)) u_tx (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .load     (tx_load),
    .load_val ({en_byte, out_bytes}),
    .shift    (tx_shift),
    .out_en   (state_q == SPX_WSHIFT),
    .sdo      (ser_out)
  );

  spx_rx_shift #(.W(RX_BITS)) u_rx (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .shift    (rx_shift),
    .sdi      (ser_in),
    .commit   (rx_commit),
    .data_out (in_bytes)
  );

  AST_ACCEPT_WRITE: assert property (@(posedge clk) disable iff (!rst_ns)
    (!busy && wr_req) |=> (busy && !in_load)) // R8
    else $error("write not taken first");

  AST_ACCEPT_READ: assert property (@(posedge clk) disable iff (!rst_ns)
    (!busy && !wr_req && rd_req) |=> in_load) // R5
    else $error("read did not start with load");

  AST_LATCH_ENDS_XFER: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(out_latch) |-> !busy) // R4
    else $error("latch ended but transfer continues");

  AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(ser_clk) && ser_clk) |-> $stable(ser_out)) // R3
    else $error("serial data moved while clock high");

  AST_INBYTES_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(in_bytes) |-> $fell(busy)) // R10
    else $error("input bytes changed outside completion");

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({ser_clk, out_latch, in_load})) // R4
    else $error("strobes overlap");

endmodule

// File: tb/tb_spx_ctrl.sv
module tb_spx_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DIV    = 4;
  localparam int HALF   = DIV / 2;
  localparam int TXB    = 56;
  localparam int RXB    = 48;
  localparam int WR_END = (TXB + 1) * DIV;
  localparam int RD_END = RXB * DIV + HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0;
  logic        rd_req = 1'b0;
  logic [5:0]  dir_mask = '0;
  logic [47:0] out_bytes = '0;
  logic [47:0] in_bytes;
  logic        busy, ser_clk, ser_out, ser_in, out_latch, in_load;

  spx_ctrl #(.NUM_PORTS(6), .PORT_W(8), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .dir_mask(dir_mask), .out_bytes(out_bytes), .in_bytes(in_bytes),
    .busy(busy), .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in),
    .out_latch(out_latch), .in_load(in_load)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Board model: output chain with storage latch, input chain with load.
  logic [55:0] bout_chain = '0;
  logic [55:0] board_q = '0;
  logic [47:0] bin_chain = '0;
  logic [47:0] board_in = '0;
  logic        sclk_prev = 1'b0;
  logic        lat_prev = 1'b0;

  assign ser_in = bin_chain[47];

  always @(posedge clk) begin
    if (in_load) bin_chain <= board_in;
    else if (ser_clk && !sclk_prev) bin_chain <= {bin_chain[46:0], 1'b0};
    if (ser_clk && !sclk_prev) bout_chain <= {bout_chain[54:0], ser_out};
    if (out_latch && !lat_prev) board_q <= bout_chain;
    sclk_prev <= ser_clk;
    lat_prev  <= out_latch;
  end

  // Cycle-level timing model.
  int          m_mode = 0;
  int          m_t = 0;
  logic [55:0] m_tx = '0;
  logic [47:0] m_rx = '0;
  logic [47:0] exp_in = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_t = 0; exp_in = '0;
    end else if (m_mode != 0) begin
      m_t++;
      if (m_mode == 1 && m_t == WR_END) m_mode = 0;
      if (m_mode == 2 && m_t == RD_END) begin
        m_mode = 0;
        exp_in = m_rx;
      end
    end else if (wr_req) begin
      m_mode = 1; m_t = 0; m_tx = {2'b00, dir_mask, out_bytes};
    end else if (rd_req) begin
      m_mode = 2; m_t = 0; m_rx = board_in;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      logic e_sclk, e_sdo, e_lat, e_ld, e_busy;
      e_sclk = 0; e_sdo = 0; e_lat = 0; e_ld = 0; e_busy = (m_mode != 0);
      if (m_mode == 1) begin
        if (m_t / DIV < TXB) begin
          e_sclk = (m_t % DIV) >= HALF;
          e_sdo  = m_tx[TXB - 1 - m_t / DIV];
        end else begin
          e_lat = 1;
        end
      end else if (m_mode == 2) begin
        if (m_t < DIV) e_ld = 1;
        else e_sclk = ((m_t - DIV) % DIV) >= HALF;
      end
      chk(ser_clk == e_sclk, "R3 ser_clk", 64'(ser_clk), 64'(e_sclk));
      chk(ser_out == e_sdo, "R2 ser_out", 64'(ser_out), 64'(e_sdo));
      chk(out_latch == e_lat, "R4 out_latch", 64'(out_latch), 64'(e_lat));
      chk(in_load == e_ld, "R5 in_load", 64'(in_load), 64'(e_ld));
      chk(busy == e_busy, "R7 busy", 64'(busy), 64'(e_busy));
      chk(in_bytes == exp_in, "R10 in_bytes", 64'(in_bytes), 64'(exp_in));
    end
  end

  task automatic request(input bit w, input bit r, input logic [47:0] ob, input logic [5:0] m);
    @(negedge clk); #1;
    out_bytes = ob; dir_mask = m; wr_req = w; rd_req = r;
    @(negedge clk); #1;
    wr_req = 0; rd_req = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_mid(input bit w, input bit r, input int after);
    repeat (after) @(negedge clk);
    #1; wr_req = w; rd_req = r; out_bytes = 48'hDEAD_BEEF_0BAD; dir_mask = 6'h3F;
    @(negedge clk); #1; wr_req = 0; rd_req = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state while held
    chk({ser_clk, ser_out, out_latch, in_load, busy} == 5'b0, "R1 strobes in reset",
        64'({ser_clk, ser_out, out_latch, in_load, busy}), 64'd0);
    chk(in_bytes == '0, "R1 in_bytes in reset", 64'(in_bytes), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({ser_clk, ser_out, out_latch, in_load, busy} == 5'b0, "R1 strobes after reset",
        64'({ser_clk, ser_out, out_latch, in_load, busy}), 64'd0);
    chk_on = 1'b1;

    // R2: asymmetric bytes, mixed mask
    request(1, 0, 48'h0123_4567_89AB, 6'b101101);
    wait_idle();
    chk(board_q == {2'b00, 6'b101101, 48'h0123_4567_89AB}, "R2 board after write A",
        64'(board_q), 64'({2'b00, 6'b101101, 48'h0123_4567_89AB}));

    // R2: all ports high-impedance, all-ones data
    request(1, 0, 48'hFFFF_FFFF_FFFF, 6'b000000);
    wait_idle();
    chk(board_q == {8'h00, 48'hFFFF_FFFF_FFFF}, "R2 board mask zero",
        64'(board_q), 64'({8'h00, 48'hFFFF_FFFF_FFFF}));

    // R9: inputs change mid-write
    fork
      request(1, 0, 48'h8001_4002_2004, 6'b111111);
      begin repeat (12) @(negedge clk); #2; out_bytes = 48'h5555_5555_5555; dir_mask = 6'b010101; end
    join
    wait_idle();
    chk(board_q == {8'h3F, 48'h8001_4002_2004}, "R9 board ignores late input",
        64'(board_q), 64'({8'h3F, 48'h8001_4002_2004}));

    // R6: read
    board_in = 48'hA1B2_C3D4_E5F6;
    request(0, 1, 48'h0, 6'h0);
    wait_idle();
    chk(in_bytes == 48'hA1B2_C3D4_E5F6, "R6 read bytes", 64'(in_bytes), 64'hA1B2_C3D4_E5F6);

    // R10: second read, sample midway
    board_in = 48'h0F1E_2D3C_4B5A;
    fork
      request(0, 1, 48'h0, 6'h0);
      begin
        repeat (60) @(negedge clk);
        chk(in_bytes == 48'hA1B2_C3D4_E5F6, "R10 in_bytes held mid-read",
            64'(in_bytes), 64'hA1B2_C3D4_E5F6);
      end
    join
    wait_idle();
    chk(in_bytes == 48'h0F1E_2D3C_4B5A, "R6 second read", 64'(in_bytes), 64'h0F1E_2D3C_4B5A);

    // R8: read request during a write is ignored
    board_in = 48'h1111_2222_3333;
    fork
      request(1, 0, 48'h7E7E_0000_C3C3, 6'b000011);
      pulse_mid(0, 1, 30);
    join
    wait_idle();
    chk(in_bytes == 48'h0F1E_2D3C_4B5A, "R8 read during write ignored",
        64'(in_bytes), 64'h0F1E_2D3C_4B5A);
    chk(board_q == {8'h03, 48'h7E7E_0000_C3C3}, "R8 write kept its data",
        64'(board_q), 64'({8'h03, 48'h7E7E_0000_C3C3}));

    // R8: write request during a read is ignored
    fork
      request(0, 1, 48'h0, 6'h0);
      pulse_mid(1, 0, 40);
    join
    wait_idle();
    chk(board_q == {8'h03, 48'h7E7E_0000_C3C3}, "R8 write during read ignored",
        64'(board_q), 64'({8'h03, 48'h7E7E_0000_C3C3}));
    chk(in_bytes == 48'h1111_2222_3333, "R6 read after ignored write",
        64'(in_bytes), 64'h1111_2222_3333);

    // R8: both requests at once, write wins
    board_in = 48'h9999_8888_7777;
    request(1, 1, 48'h0102_0408_1020, 6'b110000);
    wait_idle();
    chk(board_q == {8'h30, 48'h0102_0408_1020}, "R8 simultaneous takes write",
        64'(board_q), 64'({8'h30, 48'h0102_0408_1020}));
    chk(in_bytes == 48'h1111_2222_3333, "R8 simultaneous drops read",
        64'(in_bytes), 64'h1111_2222_3333);

    chk_on = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule